// File: doc/BRIEF.md
# Byte-Wide Host Slave Port with Buffers

This block lets an external host treat the chip as a byte-wide peripheral. The host drives an active-low chip select, active-low read and write strobes, an 8-bit data bus and two address lines. Inside the chip, a local processor sees two banks of four byte buffers:

- **Write buffers** are filled by the host and drained by the local side.
- **Read buffers** are loaded by the local side and returned to the host.

Each buffer has a status flag. Host writes set a per-buffer full flag. Host reads set a per-buffer empty flag. Two sticky error flags record a host write to a full buffer and a host read of an empty buffer.

A 2-bit configuration field picks one of four port modes:

- **Single-byte port:** uses buffer 0 only.
- **Sequential port:** host writes and reads walk buffers 0..3 in order, each direction with its own wrapping pointer.
- **Addressed port:** the host address lines select the buffer.
- **Off:** the host pins have no effect.

The host strobes pass through a two-stage synchronizer. An access completes when its strobe returns high while chip select is still low.

A separate 2-bit field sets when the interrupt fires:

- never;
- after every completed host access;
- only on an access that reaches the last buffer, or the last address.

Top module: `byte_port_slave`

## Requirements
- R1: After reset all full flags are 0, all empty flags are 1, both error flags are 0, irq is 0 and both sequential pointers point at buffer 0.
- R2: In single-byte mode (cfg_mode=00) a completed host write stores host_din in write buffer 0 and sets in_full[0]. A local read (loc_rd_en with loc_rd_idx=0) shows that byte on loc_rd_data and clears in_full[0] at the next clock edge.
- R3: In single-byte mode, while chip select and the read strobe are low, host_doe is 1 and host_dout shows read buffer 0. The completed read sets out_empty[0]. A local write to index 0 loads the buffer and clears out_empty[0].
- R4: In sequential mode (cfg_mode=01) successive host writes fill write buffers 0,1,2,3, then wrap to 0.
- R5: In sequential mode successive host reads return read buffers 0,1,2,3, then wrap to 0. Each read sets the empty flag of the buffer it returned.
- R6: In addressed mode (cfg_mode=10) host_addr selects the buffer for both host reads and host writes.
- R7: A host write to a buffer whose full flag is set leaves the stored byte unchanged and sets ovf. ovf stays set until loc_clr_err is pulsed.
- R8: A host read of a buffer whose empty flag is already set sets unf. unf stays set until loc_clr_err is pulsed.
- R9: With cfg_irq=01, every completed host access gives a one-cycle irq pulse.
- R10: With cfg_irq=11 in sequential mode, irq pulses only for a host write to write buffer 3 or a host read from read buffer 3.
- R11: With cfg_irq=11 in addressed mode, irq pulses only for a host access with host_addr=3.
- R12: cfg_irq=00 or 10 gives no irq. cfg_mode=11 gives no irq, keeps host_doe at 0, and leaves every flag and buffer unchanged on host strobes.
- R13: A strobe that rises while chip select is high has no effect. A completed access changes flags and irq on the third rising clock edge after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Port mode: 00 single, 01 sequential, 10 addressed, 11 off |
| cfg_irq | input | 2 | Interrupt mode: 00 none, 01 every access, 10 none, 11 last buffer/address |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Host address, used in addressed mode |
| host_din | input | 8 | Data written by the host |
| host_dout | output | 8 | Data returned to the host |
| host_doe | output | 1 | Drive enable for host_dout |
| loc_wr_en | input | 1 | Local write into a read buffer |
| loc_wr_idx | input | 2 | Read buffer index for the local write |
| loc_wr_data | input | 8 | Local write data |
| loc_rd_en | input | 1 | Local read of a write buffer; clears its full flag |
| loc_rd_idx | input | 2 | Write buffer index for the local read |
| loc_rd_data | output | 8 | Content of the selected write buffer |
| loc_clr_err | input | 1 | Clears ovf and unf |
| in_full | output | 4 | Per-buffer full flags of the write buffers |
| out_empty | output | 4 | Per-buffer empty flags of the read buffers |
| ovf | output | 1 | Sticky host write overflow |
| unf | output | 1 | Sticky host read underflow |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Host-side results pass through two synchronizer stages and one edge-detect register. They therefore land on the third rising edge after a strobe rises. The bench holds chip select low and waits five clock cycles after each strobe before it samples flags, and it counts irq pulses on every rising edge. Read data is combinational from the pins, so the bench samples host_dout and host_doe at a falling edge while the read strobe is still low. Local reads and writes act on the next rising edge, and their effect is sampled at the falling edge that follows.

// File: rtl/bps_pkg.sv
package bps_pkg;
    parameter int DATA_W = 8;
    parameter int NBUF   = 4;
    localparam int IDX_W = $clog2(NBUF);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBUF - 1);

    typedef enum logic [1:0] {
        PM_SINGLE = 2'b00,
        PM_SEQ    = 2'b01,
        PM_ADDR   = 2'b10,
        PM_OFF    = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        IM_NONE  = 2'b00,
        IM_EVERY = 2'b01,
        IM_RSVD  = 2'b10,
        IM_LAST  = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic              wr_done;
        logic              rd_done;
        logic [IDX_W-1:0]  wr_idx;
        logic [IDX_W-1:0]  rd_idx;
        logic [IDX_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
    } host_evt_t;

    function automatic logic irq_fire(port_mode_e m, irq_mode_e im, host_evt_t e);
        logic any;
        any = e.wr_done | e.rd_done;
        case (im)
            IM_EVERY: irq_fire = any;
            IM_LAST: begin
                if (m == PM_SEQ)
                    irq_fire = (e.wr_done && e.wr_idx == LAST_IDX) ||
                               (e.rd_done && e.rd_idx == LAST_IDX);
                else if (m == PM_ADDR)
                    irq_fire = any && (e.addr == LAST_IDX);
                else
                    irq_fire = 1'b0;
            end
            default: irq_fire = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic level_n,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], async_n};
            prev <= sh[STAGES-1];
        end
    end

    assign level_n = sh[STAGES-1];
    assign rise    = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/buf_bank.sv
module buf_bank
    import bps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_evt_t         evt,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] dout,
    input  logic              loc_wr_en,
    input  logic [IDX_W-1:0]  loc_wr_idx,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_rd_en,
    input  logic [IDX_W-1:0]  loc_rd_idx,
    output logic [DATA_W-1:0] loc_rd_data,
    input  logic              loc_clr_err,
    output logic [NBUF-1:0]   in_full,
    output logic [NBUF-1:0]   out_empty,
    output logic              ovf,
    output logic              unf
);
    logic [DATA_W-1:0] wbuf [NBUF];
    logic [DATA_W-1:0] rbuf [NBUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                wbuf[i] <= '0;
                rbuf[i] <= '0;
            end
            in_full   <= '0;
            out_empty <= '1;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            // local side first; host events below take priority
            if (loc_rd_en) in_full[loc_rd_idx] <= 1'b0;
            if (loc_wr_en) begin
                rbuf[loc_wr_idx]      <= loc_wr_data;
                out_empty[loc_wr_idx] <= 1'b0;
            end
            if (loc_clr_err) begin
                ovf <= 1'b0;
                unf <= 1'b0;
            end
            if (evt.wr_done) begin
                if (in_full[evt.wr_idx]) begin
                    ovf <= 1'b1;
                end else begin
                    wbuf[evt.wr_idx]    <= evt.wdata;
                    in_full[evt.wr_idx] <= 1'b1;
                end
            end
            if (evt.rd_done) begin
                if (out_empty[evt.rd_idx]) unf <= 1'b1;
                out_empty[evt.rd_idx] <= 1'b1;
            end
        end
    end

    assign dout        = rbuf[rd_sel];
    assign loc_rd_data = wbuf[loc_rd_idx];
endmodule

// File: rtl/byte_port_slave.sv
module byte_port_slave
    import bps_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_irq,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              loc_wr_en,
    input  logic [IDX_W-1:0]  loc_wr_idx,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_rd_en,
    input  logic [IDX_W-1:0]  loc_rd_idx,
    output logic [DATA_W-1:0] loc_rd_data,
    input  logic              loc_clr_err,
    output logic [NBUF-1:0]   in_full,
    output logic [NBUF-1:0]   out_empty,
    output logic              ovf,
    output logic              unf,
    output logic              irq
);
    localparam int NSIG = 3;   // 2: chip select, 1: read, 0: write

    port_mode_e       mode;
    irq_mode_e        imode;
    logic [NSIG-1:0]  raw_n, lvl_n, rise;
    logic             active, cs_on;
    logic [IDX_W-1:0] wr_ptr, rd_ptr, wr_sel, rd_sel;
    host_evt_t        evt;

    assign mode   = port_mode_e'(cfg_mode);
    assign imode  = irq_mode_e'(cfg_irq);
    assign active = (mode != PM_OFF);
    assign raw_n  = {host_cs_n, host_rd_n, host_wr_n};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_n (raw_n[g]),
            .level_n (lvl_n[g]),
            .rise    (rise[g])
        );
    end

    assign cs_on = ~lvl_n[2];

    always_comb begin
        case (mode)
            PM_SEQ:  begin wr_sel = wr_ptr;    rd_sel = rd_ptr;    end
            PM_ADDR: begin wr_sel = host_addr; rd_sel = host_addr; end
            default: begin wr_sel = '0;        rd_sel = '0;        end
        endcase
    end

    always_comb begin
        evt.wr_done = rise[0] & cs_on & active;
        evt.rd_done = rise[1] & cs_on & active;
        evt.wr_idx  = wr_sel;
        evt.rd_idx  = rd_sel;
        evt.addr    = host_addr;
        evt.wdata   = host_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            irq    <= 1'b0;
        end else begin
            if (mode == PM_SEQ && evt.wr_done) wr_ptr <= wr_ptr + 1'b1;
            if (mode == PM_SEQ && evt.rd_done) rd_ptr <= rd_ptr + 1'b1;
            irq <= irq_fire(mode, imode, evt);
        end
    end

    assign host_doe = active & ~host_cs_n & ~host_rd_n;

    buf_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rd_sel      (rd_sel),
        .dout        (host_dout),
        .loc_wr_en   (loc_wr_en),
        .loc_wr_idx  (loc_wr_idx),
        .loc_wr_data (loc_wr_data),
        .loc_rd_en   (loc_rd_en),
        .loc_rd_idx  (loc_rd_idx),
        .loc_rd_data (loc_rd_data),
        .loc_clr_err (loc_clr_err),
        .in_full     (in_full),
        .out_empty   (out_empty),
        .ovf         (ovf),
        .unf         (unf)
    );
endmodule

// File: rtl/bps_checker.sv
module bps_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic [1:0] cfg_irq,
    input logic       loc_clr_err,
    input logic       ovf,
    input logic       unf,
    input logic       irq
);
    a_r12_off_no_irq: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b11) |=> !irq);

    a_r12_quiet_irq_mode: assert property (@(posedge clk) disable iff (rst)
        (cfg_irq == 2'b00 || cfg_irq == 2'b10) |=> !irq);

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !loc_clr_err) |=> ovf);

    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (unf && !loc_clr_err) |=> unf);
endmodule

bind byte_port_slave bps_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_mode    (cfg_mode),
    .cfg_irq     (cfg_irq),
    .loc_clr_err (loc_clr_err),
    .ovf         (ovf),
    .unf         (unf),
    .irq         (irq)
);

// File: tb/sim_byte_port_slave.sv
module sim_byte_port_slave;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00, cfg_irq = 2'b00;
    logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [1:0] host_addr = 2'b00;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       host_doe;
    logic       loc_wr_en = 1'b0, loc_rd_en = 1'b0, loc_clr_err = 1'b0;
    logic [1:0] loc_wr_idx = 2'b00, loc_rd_idx = 2'b00;
    logic [7:0] loc_wr_data = 8'h00;
    logic [7:0] loc_rd_data;
    logic [3:0] in_full, out_empty;
    logic       ovf, unf, irq;

    int n_chk = 0, n_bad = 0, irq_seen = 0, irq_exp = 0;
    bit done = 1'b0;

    logic [7:0] wb_m [4];
    logic [7:0] rb_m [4];
    logic [3:0] full_m = 4'h0, empty_m = 4'hF;
    bit         ovf_m = 1'b0, unf_m = 1'b0;
    logic [1:0] wp_m = 2'd0, rp_m = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_port_slave u0 (.*);

    always @(posedge clk) if (!rst && irq) irq_seen++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_fire(logic [1:0] m, logic [1:0] im, logic [1:0] idx, logic [1:0] a);
        if (m == 2'b11) return 1'b0;
        if (im == 2'b01) return 1'b1;
        if (im == 2'b11) begin
            if (m == 2'b01) return idx == 2'd3;
            if (m == 2'b10) return a == 2'd3;
        end
        return 1'b0;
    endfunction

    function automatic logic [1:0] pick(logic [1:0] ptr, logic [1:0] a);
        if (cfg_mode == 2'b01) return ptr;
        if (cfg_mode == 2'b10) return a;
        return 2'd0;
    endfunction

    task automatic check_state(string req);
        chk({req, " in_full"}, in_full, full_m);
        chk({req, " out_empty"}, out_empty, empty_m);
        chk({req, " ovf"}, ovf, ovf_m);
        chk({req, " unf"}, unf, unf_m);
        chk({req, " irq count"}, irq_seen, irq_exp);
    endtask

    // host access: rd=1 read, else write; cs=0 leaves chip select high
    task automatic host_op(bit rd, logic [1:0] a, logic [7:0] d, bit cs, string req);
        logic [1:0] idx;
        logic [7:0] got;
        bit         oe;
        @(negedge clk);
        host_addr = a;
        host_din  = d;
        host_cs_n = ~cs;
        repeat (2) @(negedge clk);
        if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        got = host_dout;
        oe  = host_doe;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (cs && cfg_mode != 2'b11) begin
            idx = pick(rd ? rp_m : wp_m, a);
            if (rd) begin
                chk({req, " host_dout"}, got, rb_m[idx]);
                chk({req, " host_doe"}, oe, 1'b1);
                if (empty_m[idx]) unf_m = 1'b1;
                empty_m[idx] = 1'b1;
                if (cfg_mode == 2'b01) rp_m = rp_m + 2'd1;
            end else begin
                if (full_m[idx]) ovf_m = 1'b1;
                else begin wb_m[idx] = d; full_m[idx] = 1'b1; end
                if (cfg_mode == 2'b01) wp_m = wp_m + 2'd1;
            end
            if (exp_fire(cfg_mode, cfg_irq, idx, a)) irq_exp++;
        end else if (rd) begin
            chk({req, " host_doe idle"}, oe, 1'b0);
        end
        check_state(req);
    endtask

    task automatic loc_read(logic [1:0] idx, string req);
        @(negedge clk);
        loc_rd_idx = idx;
        loc_rd_en  = 1'b1;
        #1 chk({req, " loc_rd_data"}, loc_rd_data, wb_m[idx]);
        @(negedge clk);
        loc_rd_en = 1'b0;
        full_m[idx] = 1'b0;
        check_state(req);
    endtask

    task automatic loc_write(logic [1:0] idx, logic [7:0] d, string req);
        @(negedge clk);
        loc_wr_idx  = idx;
        loc_wr_data = d;
        loc_wr_en   = 1'b1;
        @(negedge clk);
        loc_wr_en = 1'b0;
        rb_m[idx] = d;
        empty_m[idx] = 1'b0;
        check_state(req);
    endtask

    task automatic clr_err(string req);
        @(negedge clk);
        loc_clr_err = 1'b1;
        @(negedge clk);
        loc_clr_err = 1'b0;
        ovf_m = 1'b0;
        unf_m = 1'b0;
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin wb_m[i] = 8'h00; rb_m[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset");
        chk("R1 host_doe", host_doe, 1'b0);

        // single-byte mode
        cfg_mode = 2'b00; cfg_irq = 2'b01;
        host_op(1'b0, 2'd2, 8'hA5, 1'b1, "R2 R9 legacy write");
        loc_read(2'd0, "R2 legacy local read");
        host_op(1'b0, 2'd0, 8'h11, 1'b1, "R2 write again");
        host_op(1'b0, 2'd0, 8'h22, 1'b1, "R7 overflow");
        loc_read(2'd0, "R7 data kept");
        host_op(1'b0, 2'd0, 8'h33, 1'b1, "R7 ovf still set");
        clr_err("R7 clear");
        loc_write(2'd0, 8'h3C, "R3 local load");
        host_op(1'b1, 2'd1, 8'h00, 1'b1, "R3 legacy read");
        host_op(1'b1, 2'd0, 8'h00, 1'b1, "R8 underflow");
        clr_err("R8 clear");
        loc_read(2'd0, "R2 drain");
        host_op(1'b0, 2'd0, 8'h5A, 1'b0, "R13 no chip select");
        host_op(1'b1, 2'd0, 8'h00, 1'b0, "R13 read without cs");
        cfg_irq = 2'b00;
        host_op(1'b0, 2'd0, 8'h66, 1'b1, "R12 irq mode none");
        loc_read(2'd0, "R12 drain");
        cfg_irq = 2'b10;
        host_op(1'b0, 2'd0, 8'h67, 1'b1, "R12 irq reserved");
        loc_read(2'd0, "R12 drain2");

        // sequential mode, last-buffer interrupt
        cfg_mode = 2'b01; cfg_irq = 2'b11;
        for (int i = 0; i < 4; i++)
            host_op(1'b0, 2'(i ^ 1), 8'h40 + 8'(i), 1'b1, "R4 R10 seq write");
        for (int i = 0; i < 4; i++) loc_read(2'(i), "R4 seq order");
        for (int i = 0; i < 4; i++) loc_write(2'(i), 8'h80 + 8'(i), "R5 load");
        for (int i = 0; i < 4; i++)
            host_op(1'b1, 2'd0, 8'h00, 1'b1, "R5 R10 seq read");
        host_op(1'b0, 2'd3, 8'h9E, 1'b1, "R4 wrap");
        loc_read(2'd0, "R4 wrap data");

        // addressed mode, address-3 interrupt
        cfg_mode = 2'b10;
        host_op(1'b0, 2'd2, 8'hC2, 1'b1, "R6 R11 addr write 2");
        host_op(1'b0, 2'd3, 8'hC3, 1'b1, "R6 R11 addr write 3");
        loc_read(2'd3, "R6 addr data 3");
        loc_read(2'd2, "R6 addr data 2");
        loc_write(2'd1, 8'hD1, "R6 load");
        host_op(1'b1, 2'd1, 8'h00, 1'b1, "R6 addr read 1");
        host_op(1'b1, 2'd3, 8'h00, 1'b1, "R11 addr read 3");
        clr_err("R8 clear addr");

        // off mode
        cfg_mode = 2'b11; cfg_irq = 2'b01;
        host_op(1'b0, 2'd0, 8'hEE, 1'b1, "R12 off write");
        host_op(1'b1, 2'd0, 8'h00, 1'b1, "R12 off read");

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [1:0] a;
            logic [7:0] d;
            op = int'($urandom_range(0, 9));
            a  = 2'($urandom_range(0, 3));
            d  = 8'($urandom_range(0, 255));
            if (n % 25 == 0) begin
                cfg_mode = 2'($urandom_range(0, 2));
                case ($urandom_range(0, 2))
                    0: cfg_irq = 2'b00;
                    1: cfg_irq = 2'b01;
                    default: cfg_irq = 2'b11;
                endcase
            end
            case (op)
                0, 1, 2: host_op(1'b0, a, d, 1'b1, "R4 R6 R7 R9 rand write");
                3, 4, 5: host_op(1'b1, a, d, 1'b1, "R5 R6 R8 R10 R11 rand read");
                6, 7:    loc_read(a, "R2 rand local read");
                8:       loc_write(a, d, "R3 rand local write");
                default: clr_err("R7 R8 rand clear");
            endcase
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule